// File: doc/BRIEF.md
# Wired Interrupt Cause Controller

This block gathers 32 interrupt request lines into one wired interrupt toward a parent interrupt controller. Every line owns a bit in a cause register. That bit latches when the line is active. One global control bit sets the sensing mode for all lines at once. In level mode a high input sets its bit. In edge mode only a low-to-high change between two consecutive clock samples sets it. A mask register decides which pending bits may drive the output. Each mask bit is 1 to block and 0 to pass.

Software reaches the block through a single-cycle register port. The port carries a byte address, a write strobe, 32-bit write data and combinational 32-bit read data. Pending bits are acknowledged by writing the cause register: each zero in the data clears the matching bit. A separate set register forces bits to 1, which lets software retrigger a line. A second control bit is a mask flag for message-signalled delivery. It is only stored and read back.

The external active-low reset asserts asynchronously. Its release is synchronised to the clock through two flops, so the block leaves reset two clock edges after the reset pin rises.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, cause reads 0x00000000, mask reads 0xFFFFFFFF, control reads 0x00000000 and irq_out is 0.
- R2: In level mode (control bit 3 = 0), a source that is high at a clock edge leaves its cause bit at 1 after that edge. A clear written while the source is still high leaves the bit at 1.
- R3: In edge mode (control bit 3 = 1), a cause bit is set only when its input was 0 at the previous clock edge and is 1 at the current one. A steadily high input does not set the bit again after it has been cleared.
- R4: A write to byte offset 0x00 clears each cause bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged. This write never sets a bit, and writing 0 clears all bits.
- R5: A write to byte offset 0x08 sets each cause bit whose data bit is 1. Reading offset 0x08 returns 0.
- R6: A hardware set of a bit (level or edge) in the same cycle as a clear of that bit leaves the bit at 1.
- R7: The mask register lives at byte offset 0x10 and is written whole. A mask bit of 1 blocks its source from irq_out.
- R8: irq_out is 1 exactly when some cause bit is 1 while its mask bit is 0. It follows the register state in the same cycle the registers change.
- R9: The control register lives at byte offset 0x28. Only bit 3 (edge mode) and bit 5 (message-delivery mask) are stored; all other bits read as 0. Bit 5 has no effect on cause or irq_out.
- R10: Any byte offset other than 0x00, 0x08, 0x10 and 0x28 reads as 0, and a write to it changes no register.
- R11: Reads have no side effects: reading the cause register repeatedly leaves its value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| src_in | input | 32 | Interrupt source lines, active high |
| irq_out | output | 1 | Wired interrupt to the parent controller |

## Verification
The embedded properties are checked on every cycle:
- a cleared bit with no set is 0 after the edge;
- any set, from software or from a source, wins over a clear;
- in edge mode no bit rises without an input edge or a software set;
- the mask holds unless it is written;
- unmapped offsets read zero.

Some behaviours only the bench's scenarios can show, because they follow from sequences rather than single-cycle relations:
- the reset values;
- the re-arming of an edge source after it falls;
- that a still-high level source cannot be acknowledged;
- that control bit 5 is inert;
- that repeated reads leave the cause register unchanged.

A behavioural model checks read data and irq_out after every clock.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam logic [7:0] OFS_CAUSE = 8'h00;
  localparam logic [7:0] OFS_SET   = 8'h08;
  localparam logic [7:0] OFS_MASK  = 8'h10;
  localparam logic [7:0] OFS_CTL   = 8'h28;
  localparam int CTL_EDGE_BIT = 3;
  localparam int CTL_MSG_BIT  = 5;
endpackage

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
  import irq_cause_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [N-1:0]  reg_wdata,
  input  logic [N-1:0]  cause_q,
  output logic [N-1:0]  mask_q,
  output logic          edge_mode,
  output logic [N-1:0]  clr_keep,
  output logic [N-1:0]  sw_set,
  output logic [N-1:0]  reg_rdata
);
  localparam logic [AW-1:0] A_CAUSE = AW'(OFS_CAUSE);
  localparam logic [AW-1:0] A_SET   = AW'(OFS_SET);
  localparam logic [AW-1:0] A_MASK  = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_CTL   = AW'(OFS_CTL);

  logic          hit_cause, hit_set, hit_mask, hit_ctl;
  logic          mask_en, ctl_en;
  logic [N-1:0]  mask_d;
  logic          edge_q, edge_d, msg_q, msg_d;

  always_comb begin
    hit_cause = (reg_addr == A_CAUSE);
    hit_set   = (reg_addr == A_SET);
    hit_mask  = (reg_addr == A_MASK);
    hit_ctl   = (reg_addr == A_CTL);
    mask_en   = reg_we && hit_mask;
    ctl_en    = reg_we && hit_ctl;
    mask_d    = reg_wdata;
    edge_d    = reg_wdata[CTL_EDGE_BIT];
    msg_d     = reg_wdata[CTL_MSG_BIT];
    clr_keep  = (reg_we && hit_cause) ? reg_wdata : '1;
    sw_set    = (reg_we && hit_set) ? reg_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      msg_q  <= 1'b0;
    end else if (ctl_en) begin
      edge_q <= edge_d;
      msg_q  <= msg_d;
    end
  end

  assign edge_mode = edge_q;

  always_comb begin
    reg_rdata = '0;
    if (hit_cause) begin
      reg_rdata = cause_q;
    end else if (hit_mask) begin
      reg_rdata = mask_q;
    end else if (hit_ctl) begin
      reg_rdata[CTL_EDGE_BIT] = edge_q;
      reg_rdata[CTL_MSG_BIT]  = msg_q;
    end
  end

  // R7: mask holds its value unless written
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_MASK) |=> $stable(mask_q));

  // R10: offsets outside the map read as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != A_CAUSE && reg_addr != A_MASK && reg_addr != A_CTL) |-> reg_rdata == '0);
endmodule

// File: rtl/irq_cause_sense.sv
module irq_cause_sense #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic         edge_mode,
  input  logic [N-1:0] clr_keep,
  input  logic [N-1:0] sw_set,
  output logic [N-1:0] cause_q
);
  logic [N-1:0] src_q;
  logic [N-1:0] hw_set;
  logic [N-1:0] cause_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_comb begin
      hw_set[i]  = edge_mode ? (src_in[i] & ~src_q[i]) : src_in[i];
      cause_d[i] = (cause_q[i] & clr_keep[i]) | sw_set[i] | hw_set[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      cause_q <= '0;
    end else begin
      src_q   <= src_in;
      cause_q <= cause_d;
    end
  end

  // R4: a cleared bit with no set in that cycle is zero afterwards
  p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cause_q & ~$past(clr_keep) & ~$past(sw_set | hw_set)) == '0);

  // R6: any set in a cycle wins over a clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cause_q & $past(sw_set | hw_set)) == $past(sw_set | hw_set));

  // R3: in edge mode a bit only rises on an input edge or a software set
  p_edge_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && edge_mode) |=>
      (cause_q & ~$past(cause_q) & ~$past(sw_set) & ~($past(src_in) & ~$past(src_q))) == '0);
endmodule

// File: rtl/irq_cause_out.sv
module irq_cause_out #(
  parameter int N = 32
) (
  input  logic [N-1:0] cause_q,
  input  logic [N-1:0] mask_q,
  output logic         irq_out
);
  logic [N-1:0] live;

  for (genvar i = 0; i < N; i++) begin : g_live
    assign live[i] = cause_q[i] & ~mask_q[i];
  end

  assign irq_out = |live;
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  input  logic [N-1:0]  src_in,
  output logic          irq_out
);
  logic          rst_meta, rst_int_n;
  logic [N-1:0]  cause_q, mask_q, clr_keep, sw_set;
  logic          edge_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  irq_cause_regs #(.N(N), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .edge_mode (edge_mode),
    .clr_keep  (clr_keep),
    .sw_set    (sw_set),
    .reg_rdata (reg_rdata)
  );

  irq_cause_sense #(.N(N)) sense_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .src_in    (src_in),
    .edge_mode (edge_mode),
    .clr_keep  (clr_keep),
    .sw_set    (sw_set),
    .cause_q   (cause_q)
  );

  irq_cause_out #(.N(N)) out_i (
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .irq_out (irq_out)
  );
endmodule

// File: tb/irq_cause_ctrl_tb_top.sv
module irq_cause_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a = 8'h00;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] src = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit cmp_en = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [31:0] m_cause, m_mask, m_prev;
  logic        m_edge, m_msg;

  always #10 clk = ~clk;

  irq_cause_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(a), .reg_we(we), .reg_wdata(wd),
    .reg_rdata(rdata), .src_in(src), .irq_out(irq)
  );

  always @(posedge clk) begin
    logic [31:0] keep, st;
    if (!rst_n) begin
      m_cause = '0; m_mask = '1; m_prev = '0; m_edge = 0; m_msg = 0;
    end else begin
      keep = (we && a == 8'h00) ? wd : 32'hFFFF_FFFF;
      st   = (we && a == 8'h08) ? wd : 32'h0;
      st   = st | (m_edge ? (src & ~m_prev) : src);
      m_cause = (m_cause & keep) | st;
      if (we && a == 8'h10) m_mask = wd;
      if (we && a == 8'h28) begin m_edge = wd[3]; m_msg = wd[5]; end
      m_prev = src;
    end
  end

  function automatic logic [31:0] model_rd(logic [7:0] ad);
    case (ad)
      8'h00: return m_cause;
      8'h10: return m_mask;
      8'h28: return {26'b0, m_msg, 1'b0, m_edge, 3'b0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare_all();
    if (cmp_en) begin
      total++;
      if (rdata !== model_rd(a) || irq !== ((m_cause & ~m_mask) != 0)) begin
        bad++;
        $display("FAIL %s model: rdata=%h exp=%h irq=%b exp=%b", cur_req, rdata,
                 model_rd(a), irq, ((m_cause & ~m_mask) != 0));
      end
    end
  endtask

  task automatic drive(input logic [7:0] ad, input logic w, input logic [31:0] d);
    @(negedge clk);
    compare_all();
    a = ad; we = w; wd = d;
  endtask

  task automatic wr(input logic [7:0] ad, input logic [31:0] d);
    drive(ad, 1'b1, d);
    drive(ad, 1'b0, 32'h0);
  endtask

  task automatic chk(input string req, input logic [7:0] ad, input logic [31:0] exp,
                     input logic exp_irq);
    drive(ad, 1'b0, 32'h0);
    @(negedge clk);
    compare_all();
    total++;
    if (rdata !== exp || irq !== exp_irq) begin
      bad++;
      $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b", req, ad, rdata, exp, irq, exp_irq);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1;
    // R1 reset values
    cur_req = "R1";
    chk("R1", 8'h00, 32'h0, 1'b0);
    chk("R1", 8'h10, 32'hFFFF_FFFF, 1'b0);
    chk("R1", 8'h28, 32'h0, 1'b0);
    // R2 level sensing, R8 output, R6 set over clear
    cur_req = "R2/R8";
    wr(8'h10, 32'hFFFF_FFEF);
    @(negedge clk); src = 32'h0000_0010;
    chk("R2", 8'h00, 32'h0000_0010, 1'b1);
    wr(8'h00, 32'h0);
    chk("R6", 8'h00, 32'h0000_0010, 1'b1);
    @(negedge clk); src = 32'h0;
    wr(8'h00, 32'h0);
    chk("R2", 8'h00, 32'h0, 1'b0);
    // R4 partial clear, R5 set register
    cur_req = "R4/R5";
    wr(8'h08, 32'hF0F0_00FF);
    chk("R5", 8'h00, 32'hF0F0_00FF, 1'b1);
    chk("R5", 8'h08, 32'h0, 1'b1);
    wr(8'h00, 32'h0000_000F);
    chk("R4", 8'h00, 32'h0000_000F, 1'b0);
    // R11 reads leave cause intact
    chk("R11", 8'h00, 32'h0000_000F, 1'b0);
    chk("R11", 8'h00, 32'h0000_000F, 1'b0);
    // R7 masking
    cur_req = "R7";
    wr(8'h10, 32'hFFFF_FFF7);
    chk("R7", 8'h00, 32'h0000_000F, 1'b1);
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R7", 8'h10, 32'hFFFF_FFFF, 1'b0);
    wr(8'h00, 32'h0);
    // R9 control storage, bit 5 inert
    cur_req = "R9";
    wr(8'h28, 32'hFFFF_FFD7);
    chk("R9", 8'h28, 32'h0000_0000, 1'b0);
    wr(8'h28, 32'hFFFF_FFFF);
    chk("R9", 8'h28, 32'h0000_0028, 1'b0);
    // R3 edge sensing
    cur_req = "R3";
    wr(8'h10, 32'h0);
    @(negedge clk); src = 32'h0000_0200;
    chk("R3", 8'h00, 32'h0000_0200, 1'b1);
    wr(8'h00, 32'h0);
    chk("R3", 8'h00, 32'h0, 1'b0);
    @(negedge clk); src = 32'h0;
    @(negedge clk); src = 32'h0000_0200; a = 8'h00; we = 1'b1; wd = 32'h0;
    chk("R6", 8'h00, 32'h0000_0200, 1'b1);
    wr(8'h00, 32'h0);
    chk("R3", 8'h00, 32'h0, 1'b0);
    // R10 unmapped
    cur_req = "R10";
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    chk("R10", 8'h04, 32'h0, 1'b0);
    chk("R10", 8'h00, 32'h0, 1'b0);
    chk("R10", 8'h10, 32'h0, 1'b0);
    chk("R10", 8'h28, 32'h0000_0028, 1'b0);
    // random traffic against the model
    cur_req = "R2/R3/R4/R5/R7/R8/R10";
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] ad;
      int sel;
      sel = $urandom_range(0, 5);
      ad = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h08 : (sel == 2) ? 8'h10 :
           (sel == 3) ? 8'h28 : (sel == 4) ? 8'h04 : 8'h00;
      drive(ad, ($urandom_range(0, 3) == 0), $urandom & $urandom);
      src = $urandom & $urandom & $urandom;
    end
    drive(8'h00, 1'b0, 32'h0);
    @(negedge clk); compare_all();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired at %s", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule